// File: doc/BRIEF.md
# Pedestrian-Aware Traffic Signal Controller

This block runs the lamps of a two-road crossing. Each road has its own active-high red, yellow and green outputs. The signal state is the value of a 4-bit phase register that steps once per second. The second is counted down from the system clock by two cascaded dividers that produce single-cycle enables. In phases 0 to 7 the east/west road has right of way first. The north/south road follows, and each green ends with a one-second yellow.

A walk button sets a request flag. The flag sets on the edge where the button is sampled high. It clears on any edge where the button is low and the phase register's top bit is set. When the request is pending as the north/south yellow ends, the phase register runs on through phases 8 to 15. In those phases both roads show red and yellow together. After phase 15 it rolls over to phase 0. A separate output shows when a request is pending.

All logic is in the system clock domain. The reset input is active-low. It clears the block at once, and its release is synchronized through two flops.

Top module: `traffic_walk_ctrl`

## Requirements
- R1: While `rst_n` is low, and until the first phase step, the controller is in phase 0. In phase 0, `ew_grn` and `ns_red` are 1, every other lamp is 0, and `walk_pending` is 0.
- R2: The phase steps once every TICK = 2^PRE_W*(SUB_LAST+1) clock cycles. The first step comes on the (TICK+2)-th rising edge after `rst_n` goes high, because the internal reset is released two edges late. Between steps the phase holds.
- R3: In phases 0 to 2, `ew_grn` and `ns_red` are lit. In phase 3, `ew_yel` and `ns_red` are lit. All other lamps are dark.
- R4: In phases 4 to 6, `ns_grn` and `ew_red` are lit. In phase 7, `ns_yel` and `ew_red` are lit. All other lamps are dark.
- R5: At a step out of phase 7 with no request pending, the phase goes to 0.
- R6: At a step out of phase 7 with a request pending, the phase goes to 8. In phases 8 to 15 the red and yellow lamps of both roads are lit and both greens are dark. A step out of phase 15 goes to phase 0.
- R7: `walk_btn` sampled high at a clock edge makes `walk_pending` 1 after that edge. The flag then stays set after the button is released until it is cleared under R8.
- R8: The request clears at the first edge where the phase is 8 to 15 and `walk_btn` is low. When the button is high and the phase is 8 to 15 in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized |
| walk_btn | input | 1 | Pedestrian button, high while pressed |
| ns_red | output | 1 | North/south red lamp |
| ns_yel | output | 1 | North/south yellow lamp |
| ns_grn | output | 1 | North/south green lamp |
| ew_red | output | 1 | East/west red lamp |
| ew_yel | output | 1 | East/west yellow lamp |
| ew_grn | output | 1 | East/west green lamp |
| walk_pending | output | 1 | High while a walk request is latched |

## Verification
The bench checks the step timing at a single exact edge. A divider that is one cycle off would light the east/west yellow early or late. It checks both outcomes of leaving phase 7. A design that ignored the request would never enter the walk phase, and one that read the raw button would miss a short press. The bench also releases the button during the walk phase, and a latch that failed to clear would start a second walk at once. It then holds the button across the end of the walk phase, and a latch where clear beats set would drop that request.

// File: rtl/tl_pkg.sv
package tl_pkg;
  localparam int PHASE_W   = 4;
  localparam int PH_EW_YEL = 3;
  localparam int PH_NS_YEL = 7;
  localparam int PH_LAST   = (1 << PHASE_W) - 1;
  typedef logic [PHASE_W-1:0] phase_t;
  typedef struct packed {
    logic red;
    logic yel;
    logic grn;
  } lamp_t;
endpackage

// File: rtl/tl_rst_sync.sv
module tl_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tl_tick_gen.sv
module tl_tick_gen #(
  parameter int PRE_W    = 18,
  parameter int SUB_LAST = 190
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int SUB_W = (SUB_LAST < 1) ? 1 : $clog2(SUB_LAST + 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [SUB_W-1:0] sub_q, sub_d;
  logic             pre_wrap, sub_wrap;

  assign pre_wrap = &pre_q;
  assign sub_wrap = (sub_q == SUB_W'(SUB_LAST));
  assign tick     = pre_wrap && sub_wrap;

  always_comb begin
    pre_d = pre_q + 1'b1;
    sub_d = sub_q;
    if (pre_wrap) sub_d = sub_wrap ? '0 : sub_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      sub_q <= '0;
    end else begin
      pre_q <= pre_d;
      sub_q <= sub_d;
    end
  end

  // one-second enable is a single-cycle pulse
  assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/tl_walk_latch.sv
module tl_walk_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic req_o
);
  logic req_q, req_d;

  always_comb begin
    req_d = req_q;
    if (set_i)      req_d = 1'b1;
    else if (clr_i) req_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign req_o = req_q;

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> req_o);
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && clr_i) |=> !req_o);
endmodule

// File: rtl/tl_phase_ctr.sv
module tl_phase_ctr
  import tl_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  logic   walk_req,
  output phase_t phase
);
  phase_t phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (tick) begin
      if (phase_q == phase_t'(PH_NS_YEL) && !walk_req) phase_d = '0;
      else if (phase_q == phase_t'(PH_LAST))            phase_d = '0;
      else                                              phase_d = phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(phase));
  assert_wrap_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && phase == phase_t'(PH_NS_YEL) && !walk_req) |=> phase == '0);
  assert_walk_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && phase == phase_t'(PH_NS_YEL) && walk_req) |=> phase == phase_t'(PH_NS_YEL + 1));
endmodule

// File: rtl/tl_lamp_dec.sv
module tl_lamp_dec
  import tl_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_t phase,
  output lamp_t  ns,
  output lamp_t  ew
);
  always_comb begin
    ns = '{red: 1'b1, yel: 1'b0, grn: 1'b0};
    ew = '{red: 1'b1, yel: 1'b0, grn: 1'b0};
    if (phase[PHASE_W-1]) begin
      ns.yel = 1'b1;
      ew.yel = 1'b1;
    end else if (phase < phase_t'(PH_EW_YEL)) begin
      ew = '{red: 1'b0, yel: 1'b0, grn: 1'b1};
    end else if (phase == phase_t'(PH_EW_YEL)) begin
      ew = '{red: 1'b0, yel: 1'b1, grn: 1'b0};
    end else if (phase < phase_t'(PH_NS_YEL)) begin
      ns = '{red: 1'b0, yel: 1'b0, grn: 1'b1};
    end else begin
      ns = '{red: 1'b0, yel: 1'b1, grn: 1'b0};
    end
  end

  assert_one_lamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !phase[PHASE_W-1] |-> ($countones(ns) == 1 && $countones(ew) == 1));
  assert_no_green_walk_R6: assert property (@(posedge clk) disable iff (!rst_n)
    phase[PHASE_W-1] |-> (!ns.grn && !ew.grn));
  assert_one_green_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ns.grn && ew.grn));
endmodule

// File: rtl/traffic_walk_ctrl.sv
module traffic_walk_ctrl #(
  parameter int PRE_W    = 18,
  parameter int SUB_LAST = 190
) (
  input  logic clk,
  input  logic rst_n,
  input  logic walk_btn,
  output logic ns_red,
  output logic ns_yel,
  output logic ns_grn,
  output logic ew_red,
  output logic ew_yel,
  output logic ew_grn,
  output logic walk_pending
);
  import tl_pkg::*;

  logic   rst_int_n;
  logic   tick;
  logic   walk_q;
  phase_t phase;
  lamp_t  ns, ew;

  tl_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .rst_sync_n(rst_int_n));

  tl_tick_gen #(.PRE_W(PRE_W), .SUB_LAST(SUB_LAST)) u_tick (
    .clk(clk), .rst_n(rst_int_n), .tick(tick));

  tl_walk_latch u_walk (
    .clk(clk), .rst_n(rst_int_n), .set_i(walk_btn),
    .clr_i(phase[PHASE_W-1]), .req_o(walk_q));

  tl_phase_ctr u_phase (
    .clk(clk), .rst_n(rst_int_n), .tick(tick), .walk_req(walk_q), .phase(phase));

  tl_lamp_dec u_dec (
    .clk(clk), .rst_n(rst_int_n), .phase(phase), .ns(ns), .ew(ew));

  assign ns_red       = ns.red;
  assign ns_yel       = ns.yel;
  assign ns_grn       = ns.grn;
  assign ew_red       = ew.red;
  assign ew_yel       = ew.yel;
  assign ew_grn       = ew.grn;
  assign walk_pending = walk_q;

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_int_n |-> (ew_grn && ns_red && !walk_pending));
endmodule

// File: tb/traffic_walk_ctrl_tb_top.sv
`timescale 1ns/1ps
module traffic_walk_ctrl_tb_top;
  localparam int PRE_W    = 2;
  localparam int SUB_LAST = 2;
  localparam int TICK     = (1 << PRE_W) * (SUB_LAST + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic walk_btn = 1'b0;
  logic ns_red, ns_yel, ns_grn, ew_red, ew_yel, ew_grn, walk_pending;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  traffic_walk_ctrl #(.PRE_W(PRE_W), .SUB_LAST(SUB_LAST)) dut_i (
    .clk(clk), .rst_n(rst_n), .walk_btn(walk_btn),
    .ns_red(ns_red), .ns_yel(ns_yel), .ns_grn(ns_grn),
    .ew_red(ew_red), .ew_yel(ew_yel), .ew_grn(ew_grn),
    .walk_pending(walk_pending));

  // Reference model from the requirements (R2, R5-R8)
  int   m_edges;
  int   m_k;
  int   m_ph;
  int   m_prev;
  logic m_walk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_edges <= 0; m_k <= 0; m_ph <= 0; m_prev <= 0; m_walk <= 1'b0;
    end else if (m_edges < 2) begin
      m_edges <= m_edges + 1;
    end else begin
      m_k <= m_k + 1;
      m_walk <= walk_btn ? 1'b1 : ((m_ph >= 8) ? 1'b0 : m_walk);
      if ((m_k + 1) % TICK == 0) begin
        m_prev <= m_ph;
        if (m_ph == 7 && !m_walk) m_ph <= 0;
        else if (m_ph == 15)      m_ph <= 0;
        else                      m_ph <= m_ph + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cmp_outputs();
    logic [5:0] exp_l, act_l;
    string tag;
    if (m_ph >= 8)      exp_l = 6'b110_110;
    else if (m_ph < 3)  exp_l = 6'b100_001;
    else if (m_ph == 3) exp_l = 6'b100_010;
    else if (m_ph < 7)  exp_l = 6'b001_100;
    else                exp_l = 6'b010_100;
    act_l = {ns_red, ns_yel, ns_grn, ew_red, ew_yel, ew_grn};
    if (m_ph == 0 && m_prev == 7)      tag = "R5";
    else if (m_ph >= 8)                tag = "R6";
    else if (m_ph <= 3)                tag = "R3";
    else                               tag = "R4";
    check(act_l == exp_l, tag, int'(act_l), int'(exp_l));
    check(walk_pending == m_walk, "R8 pending", int'(walk_pending), int'(m_walk));
  endtask

  task automatic run_cmp(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      cmp_outputs();
    end
  endtask

  task automatic wait_phase(input int p);
    while (m_ph != p) run_cmp(1);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    walk_btn = 1'b0;
    repeat (3) @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // R1 reset state, R2 exact step timing
  task automatic t_reset_timing();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(ew_grn && ns_red && !ns_grn && !ew_yel && !walk_pending, "R1 async",
          int'({ew_grn, ns_red, walk_pending}), 3'b110);
    repeat (3) @(negedge clk);
    check({ns_red, ns_yel, ns_grn, ew_red, ew_yel, ew_grn} == 6'b100_001, "R1 held",
          int'({ns_red, ns_yel, ns_grn, ew_red, ew_yel, ew_grn}), 6'b100_001);
    rst_n = 1'b1;
    run_cmp(3 * TICK + 1);
    check(ew_yel == 1'b0, "R2 before step", int'(ew_yel), 0);
    run_cmp(1);
    check(ew_yel == 1'b1, "R2 at step", int'(ew_yel), 1);
  endtask

  // R3 R4 R5: full cycle without a request
  task automatic t_normal_cycle();
    wait_phase(7);
    run_cmp(TICK);
    check(ew_grn == 1'b1 && ns_yel == 1'b0, "R5 wrap", int'({ew_grn, ns_yel}), 2'b10);
    run_cmp(8 * TICK);
  endtask

  // R6 R7: one-cycle press, walk inserted, latch cleared in walk
  task automatic t_walk_press();
    wait_phase(1);
    walk_btn = 1'b1;
    run_cmp(1);
    walk_btn = 1'b0;
    check(walk_pending == 1'b1, "R7 set", int'(walk_pending), 1);
    run_cmp(TICK);
    check(walk_pending == 1'b1, "R7 held", int'(walk_pending), 1);
    wait_phase(8);
    check(ns_red && ns_yel && ew_red && ew_yel && !ns_grn && !ew_grn, "R6 walk lamps",
          int'({ns_red, ns_yel, ew_red, ew_yel}), 4'b1111);
    run_cmp(1);
    check(walk_pending == 1'b0, "R8 cleared", int'(walk_pending), 0);
    wait_phase(0);
    check(ew_grn == 1'b1, "R6 after 15", int'(ew_grn), 1);
  endtask

  // R8: press released inside walk is discarded
  task automatic t_press_in_walk();
    wait_phase(7);
    walk_btn = 1'b1;
    wait_phase(10);
    check(walk_pending == 1'b1, "R8 set wins", int'(walk_pending), 1);
    walk_btn = 1'b0;
    run_cmp(1);
    check(walk_pending == 1'b0, "R8 release clears", int'(walk_pending), 0);
    wait_phase(7);
    run_cmp(TICK);
    check(ew_grn == 1'b1, "R5 no second walk", int'(ew_grn), 1);
  endtask

  // R8: button held across the end of walk keeps the request
  task automatic t_hold_through();
    wait_phase(7);
    walk_btn = 1'b1;
    wait_phase(15);
    check(walk_pending == 1'b1, "R8 held at 15", int'(walk_pending), 1);
    wait_phase(1);
    walk_btn = 1'b0;
    run_cmp(1);
    check(walk_pending == 1'b1, "R8 survives wrap", int'(walk_pending), 1);
    wait_phase(7);
    run_cmp(TICK);
    check(ns_yel && ew_yel, "R6 second walk", int'({ns_yel, ew_yel}), 2'b11);
  endtask

  initial begin
    t_reset_timing();
    t_normal_cycle();
    t_walk_press();
    t_press_in_walk();
    t_hold_through();
    apply_reset();
    run_cmp(1);
    check(ew_grn && !walk_pending, "R1 reapply", int'({ew_grn, walk_pending}), 2'b10);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule